// File: doc/BRIEF.md
# Same-Track Routing Switch Box

This block is the programmable junction placed where a horizontal routing channel crosses a vertical one. Each of its four sides (north, east, south, west) carries a bundle of wire segments, one per track, and each segment reaches only as far as the neighbouring box. Configuration bits close pass connections between sides. A connection only ever joins wires that share a track number, so track k on one side can reach nothing but track k on the other three. A route longer than one segment is built by closing switches in box after box, either straight through or around a corner.

Each closed connection acts as a bidirectional short. This is modelled in synthesizable form with an input, an output and an output-enable per side and track. A side that is driving its track raises a per-wire source flag. For every track the box works out which sides are joined, directly or through other sides. It then drives each joined side that is not itself a source with the value of the single source in its group. Two sources shorted together raise a per-track conflict flag, and every output on that track is released. The 6×W configuration bits are shifted in serially while a load enable is held. All output drivers stay off for as long as the load enable is high.

Top module: `sb_switchbox`

## Requirements
- R1: After reset every configuration bit is zero, so with any inputs and source flags all output-enables are low and no conflict flag is set.
- R2: While `cfg_en` is high, every output-enable on every side is low, whatever the stored configuration and source flags.
- R3: On each rising clock edge with `cfg_en` high, the configuration shifts one place toward higher indices and `cfg_bit` enters at index 0. With `cfg_en` low the configuration holds. Index 6k+p controls pair p of track k, where p = 0 is north–south, 1 east–west, 2 north–east, 3 north–west, 4 south–east and 5 south–west. After 6×W loads, the bit shifted in first sits at index 6W−1.
- R4: On one track, if a group of sides joined by closed pairs, directly or through other sides of the group, holds exactly one source, every other side of the group has its output-enable high and outputs the source's input value. Straight-through, corner and multi-hop joins all count.
- R5: A side never has its output-enable high while its own source flag is high.
- R6: A configuration bit of track k changes nothing on any other track.
- R7: If any group on track k holds two or more sources, `conflict[k]` is high and all four output-enables of track k are low.
- R8: Sources in separate, unjoined groups of the same track do not set the conflict flag.
- R9: A side in a group with no source, including a side joined to nothing, has its output-enable low.
- R10: An output whose output-enable is low reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Active-low asynchronous reset; clears the configuration |
| cfg_en | input | 1 | Serial configuration load enable |
| cfg_bit | input | 1 | Serial configuration data |
| n_in | input | W | North side wire values, one per track |
| n_src | input | W | North side source flags |
| n_out | output | W | North side driven values |
| n_oe | output | W | North side output-enables |
| e_in | input | W | East side wire values |
| e_src | input | W | East side source flags |
| e_out | output | W | East side driven values |
| e_oe | output | W | East side output-enables |
| s_in | input | W | South side wire values |
| s_src | input | W | South side source flags |
| s_out | output | W | South side driven values |
| s_oe | output | W | South side output-enables |
| w_in | input | W | West side wire values |
| w_src | input | W | West side source flags |
| w_out | output | W | West side driven values |
| w_oe | output | W | West side output-enables |
| conflict | output | W | Per-track short-circuit flag |

## Verification
The hardest situations to reach are multi-hop joins and mixed groups on one track. One example is a group with two sources whose conflict must still mute an unrelated, correctly sourced pair. Another is a side joined to the source only through a third side. Reaching them needs particular combinations of closed pairs together with particular source sets. The bench therefore loads every one of the 64 pair patterns, each time with a different pattern on each track. Under each pattern it applies all 16 source sets with varying wire values. Every output is compared against a group-labelling model that the bench computes itself.

// File: rtl/sb_pkg.sv
package sb_pkg;

  localparam int unsigned NSIDE = 4;
  localparam int unsigned NPAIR = 6;

  typedef enum logic [1:0] {
    SIDE_N = 2'd0,
    SIDE_E = 2'd1,
    SIDE_S = 2'd2,
    SIDE_W = 2'd3
  } side_e;

  typedef logic [NSIDE*NSIDE-1:0] link_mat_t;

  // first end of pair p
  function automatic int unsigned pair_a(input int unsigned p);
    case (p)
      0: return 0;
      1: return 1;
      2: return 0;
      3: return 0;
      4: return 2;
      default: return 2;
    endcase
  endfunction

  // second end of pair p
  function automatic int unsigned pair_b(input int unsigned p);
    case (p)
      0: return 2;
      1: return 3;
      2: return 1;
      3: return 3;
      4: return 1;
      default: return 3;
    endcase
  endfunction

  // direct links, reflexive and symmetric
  function automatic link_mat_t links_of(input logic [NPAIR-1:0] pairs);
    link_mat_t m;
    m = '0;
    for (int unsigned s = 0; s < NSIDE; s++) begin
      m[s*NSIDE+s] = 1'b1;
    end
    for (int unsigned p = 0; p < NPAIR; p++) begin
      if (pairs[p]) begin
        m[pair_a(p)*NSIDE+pair_b(p)] = 1'b1;
        m[pair_b(p)*NSIDE+pair_a(p)] = 1'b1;
      end
    end
    return m;
  endfunction

  // one squaring step of a boolean matrix
  function automatic link_mat_t square(input link_mat_t m);
    link_mat_t r;
    r = '0;
    for (int unsigned a = 0; a < NSIDE; a++) begin
      for (int unsigned b = 0; b < NSIDE; b++) begin
        for (int unsigned k = 0; k < NSIDE; k++) begin
          r[a*NSIDE+b] = r[a*NSIDE+b] | (m[a*NSIDE+k] & m[k*NSIDE+b]);
        end
      end
    end
    return r;
  endfunction

  // row a of a matrix
  function automatic logic [NSIDE-1:0] row_of(input link_mat_t m, input int unsigned a);
    logic [NSIDE-1:0] r;
    for (int unsigned b = 0; b < NSIDE; b++) begin
      r[b] = m[a*NSIDE+b];
    end
    return r;
  endfunction

  // number of set bits in a side mask
  function automatic logic [2:0] count_sides(input logic [NSIDE-1:0] v);
    logic [2:0] c;
    c = '0;
    for (int unsigned b = 0; b < NSIDE; b++) begin
      c = c + {2'b00, v[b]};
    end
    return c;
  endfunction

endpackage

// File: rtl/sb_cfg_chain.sv
module sb_cfg_chain #(
  parameter int unsigned NBITS = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_bit,
  output logic [NBITS-1:0] cfg_q
);

  logic [NBITS-1:0] chain_q;
  logic [NBITS-1:0] chain_d;
  logic             shift_now;

  assign shift_now = cfg_en;

  generate
    if (NBITS == 1) begin : g_single
      assign chain_d = cfg_bit;
    end else begin : g_multi
      assign chain_d = {chain_q[NBITS-2:0], cfg_bit};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else if (shift_now) begin
      chain_q <= chain_d;
    end
  end

  assign cfg_q = chain_q;

  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> cfg_q[0] == $past(cfg_bit)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg_q)); // R3

endmodule

// File: rtl/sb_track_reach.sv
module sb_track_reach
  import sb_pkg::*;
(
  input  logic [NPAIR-1:0] pairs,
  output link_mat_t        reach
);

  link_mat_t direct;
  link_mat_t hop2;
  link_mat_t hop4;

  assign direct = links_of(pairs);
  assign hop2   = square(direct);
  assign hop4   = square(hop2);
  assign reach  = hop4;

  always_comb begin
    for (int unsigned a = 0; a < NSIDE; a++) begin
      for (int unsigned b = 0; b < NSIDE; b++) begin
        AST_REACH_SYM: assert (reach[a*NSIDE+b] == reach[b*NSIDE+a]); // R4
      end
    end
  end

endmodule

// File: rtl/sb_track_drive.sv
module sb_track_drive
  import sb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  link_mat_t        reach,
  input  logic [NSIDE-1:0] wire_in,
  input  logic [NSIDE-1:0] src,
  output logic [NSIDE-1:0] wire_out,
  output logic [NSIDE-1:0] wire_oe,
  output logic             clash
);

  logic [NSIDE-1:0] grp_mask [NSIDE];
  logic [2:0]       grp_srcs [NSIDE];
  logic [NSIDE-1:0] multi_src;
  logic [NSIDE-1:0] one_src;
  logic [NSIDE-1:0] grp_val;

  genvar gs;
  generate
    for (gs = 0; gs < NSIDE; gs++) begin : g_side
      assign grp_mask[gs]  = row_of(reach, gs);
      assign grp_srcs[gs]  = count_sides(grp_mask[gs] & src);
      assign multi_src[gs] = grp_srcs[gs] > 3'd1;
      assign one_src[gs]   = grp_srcs[gs] == 3'd1;
      assign grp_val[gs]   = |(grp_mask[gs] & src & wire_in);
    end
  endgenerate

  assign clash    = |multi_src;
  assign wire_oe  = (hold || clash) ? '0 : (one_src & ~src);
  assign wire_out = grp_val & wire_oe;

  AST_CLASH_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    clash |-> wire_oe == '0); // R7
  AST_NO_BACKDRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (wire_oe & src) == '0); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wire_out & ~wire_oe) == '0); // R10
  AST_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> wire_oe == '0); // R9

endmodule

// File: rtl/sb_switchbox.sv
module sb_switchbox
  import sb_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_en,
  input  logic         cfg_bit,
  input  logic [W-1:0] n_in,
  input  logic [W-1:0] n_src,
  output logic [W-1:0] n_out,
  output logic [W-1:0] n_oe,
  input  logic [W-1:0] e_in,
  input  logic [W-1:0] e_src,
  output logic [W-1:0] e_out,
  output logic [W-1:0] e_oe,
  input  logic [W-1:0] s_in,
  input  logic [W-1:0] s_src,
  output logic [W-1:0] s_out,
  output logic [W-1:0] s_oe,
  input  logic [W-1:0] w_in,
  input  logic [W-1:0] w_src,
  output logic [W-1:0] w_out,
  output logic [W-1:0] w_oe,
  output logic [W-1:0] conflict
);

  localparam int unsigned CFG_BITS = NPAIR * W;

  logic [CFG_BITS-1:0] cfg_q;
  logic [W-1:0]        any_oe;

  sb_cfg_chain #(.NBITS(CFG_BITS)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_en  (cfg_en),
    .cfg_bit (cfg_bit),
    .cfg_q   (cfg_q)
  );

  genvar gt;
  generate
    for (gt = 0; gt < W; gt++) begin : g_track
      link_mat_t        reach;
      logic [NSIDE-1:0] t_in;
      logic [NSIDE-1:0] t_src;
      logic [NSIDE-1:0] t_out;
      logic [NSIDE-1:0] t_oe;
      logic             t_clash;

      assign t_in  = {w_in[gt],  s_in[gt],  e_in[gt],  n_in[gt]};
      assign t_src = {w_src[gt], s_src[gt], e_src[gt], n_src[gt]};

      sb_track_reach u_reach (
        .pairs (cfg_q[gt*NPAIR +: NPAIR]),
        .reach (reach)
      );

      sb_track_drive u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (cfg_en),
        .reach    (reach),
        .wire_in  (t_in),
        .src      (t_src),
        .wire_out (t_out),
        .wire_oe  (t_oe),
        .clash    (t_clash)
      );

      assign n_out[gt]    = t_out[SIDE_N];
      assign e_out[gt]    = t_out[SIDE_E];
      assign s_out[gt]    = t_out[SIDE_S];
      assign w_out[gt]    = t_out[SIDE_W];
      assign n_oe[gt]     = t_oe[SIDE_N];
      assign e_oe[gt]     = t_oe[SIDE_E];
      assign s_oe[gt]     = t_oe[SIDE_S];
      assign w_oe[gt]     = t_oe[SIDE_W];
      assign conflict[gt] = t_clash;
      assign any_oe[gt]   = |t_oe;
    end
  endgenerate

  AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> any_oe == '0); // R2
  AST_CLASH_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((conflict & (n_oe | e_oe | s_oe | w_oe)) == '0)); // R7

endmodule

// File: tb/sb_switchbox_bench.sv
module sb_switchbox_bench;

  localparam int W = 4;
  localparam int NB = 6 * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0;
  logic cfg_bit = 1'b0;
  logic [3:0][W-1:0] sin;
  logic [3:0][W-1:0] ssrc;
  logic [W-1:0] n_out, e_out, s_out, w_out;
  logic [W-1:0] n_oe, e_oe, s_oe, w_oe;
  logic [W-1:0] conflict;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  sb_switchbox #(.W(W)) u_sb_switchbox (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .n_in(sin[0]), .n_src(ssrc[0]), .n_out(n_out), .n_oe(n_oe),
    .e_in(sin[1]), .e_src(ssrc[1]), .e_out(e_out), .e_oe(e_oe),
    .s_in(sin[2]), .s_src(ssrc[2]), .s_out(s_out), .s_oe(s_oe),
    .w_in(sin[3]), .w_src(ssrc[3]), .w_out(w_out), .w_oe(w_oe),
    .conflict(conflict)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic get_oe(input int s, input int t);
    case (s)
      0: return n_oe[t];
      1: return e_oe[t];
      2: return s_oe[t];
      default: return w_oe[t];
    endcase
  endfunction

  function automatic logic get_out(input int s, input int t);
    case (s)
      0: return n_out[t];
      1: return e_out[t];
      2: return s_out[t];
      default: return w_out[t];
    endcase
  endfunction

  task automatic load_cfg(input logic [NB-1:0] v);
    for (int i = NB - 1; i >= 0; i--) begin
      @(negedge clk);
      cfg_en = 1'b1;
      cfg_bit = v[i];
    end
    @(negedge clk);
    cfg_en = 1'b0;
    cfg_bit = 1'b0;
  endtask

  // group labelling model of one track; checks every output of it
  task automatic check_track(input int t, input logic [5:0] pr);
    int lab [4];
    int cnt [4];
    int pa [6];
    int pb [6];
    logic econf;
    pa = '{0, 1, 0, 0, 2, 2};
    pb = '{2, 3, 1, 3, 1, 3};
    for (int s = 0; s < 4; s++) lab[s] = s;
    for (int it = 0; it < 4; it++) begin
      for (int p = 0; p < 6; p++) begin
        if (pr[p]) begin
          int m;
          m = (lab[pa[p]] < lab[pb[p]]) ? lab[pa[p]] : lab[pb[p]];
          for (int s = 0; s < 4; s++)
            if (lab[s] == lab[pa[p]] || lab[s] == lab[pb[p]]) lab[s] = m;
        end
      end
    end
    econf = 1'b0;
    for (int s = 0; s < 4; s++) begin
      cnt[s] = 0;
      for (int o = 0; o < 4; o++)
        if (lab[o] == lab[s] && ssrc[o][t]) cnt[s]++;
      if (cnt[s] > 1) econf = 1'b1;
    end
    check(econf ? "R7" : "R8", int'(conflict[t]), int'(econf));
    for (int s = 0; s < 4; s++) begin
      logic eoe;
      logic eval;
      eoe = !econf && cnt[s] == 1 && !ssrc[s][t];
      eval = 1'b0;
      for (int o = 0; o < 4; o++)
        if (eoe && lab[o] == lab[s] && ssrc[o][t]) eval = sin[o][t];
      if (econf) check("R7", int'(get_oe(s, t)), 0);
      else if (ssrc[s][t]) check("R5", int'(get_oe(s, t)), 0);
      else if (cnt[s] == 0) check("R9", int'(get_oe(s, t)), 0);
      else check("R4 R6", int'(get_oe(s, t)), int'(eoe));
      check(eoe ? "R4" : "R10", int'(get_out(s, t)), int'(eval));
    end
  endtask

  initial begin
    #2000000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    sin = '0;
    ssrc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: cleared configuration, every source raised
    ssrc = '1;
    sin = '1;
    #2;
    check("R1", int'(n_oe | e_oe | s_oe | w_oe), 0);
    check("R1", int'(conflict), 0);
    ssrc = '0;

    // R2: fully joined, single north source, then raise load enable
    load_cfg('1);
    ssrc[0] = '1;
    sin[0] = 4'b1010;
    #2;
    check("R4", int'(s_oe & e_oe & w_oe), 15);
    check("R4", int'(s_out), 10);
    @(negedge clk);
    cfg_en = 1'b1;
    cfg_bit = 1'b1;
    #2;
    check("R2", int'(n_oe | e_oe | s_oe | w_oe), 0);
    @(negedge clk);
    cfg_en = 1'b0;
    ssrc = '0;

    // R3 R6: full sweep of pair patterns, distinct per track
    for (int p = 0; p < 64; p++) begin
      logic [NB-1:0] v;
      for (int t = 0; t < W; t++) v[t*6 +: 6] = 6'((p + t * 17) % 64);
      load_cfg(v);
      for (int sc = 0; sc < 16; sc++) begin
        @(negedge clk);
        for (int s = 0; s < 4; s++) begin
          for (int t = 0; t < W; t++) begin
            ssrc[s][t] = sc[(s + t) % 4];
            sin[s][t] = 1'(((p * 7 + sc * 3 + s * 5 + t) >> 1) & 1);
          end
        end
        #2;
        for (int t = 0; t < W; t++) check_track(t, v[t*6 +: 6]);
      end
      ssrc = '0;
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule